// File: doc/BRIEF.md
# Interrupt Pin Release Controller

This block owns the active-low interrupt line of a multi-port power controller. Single-cycle event pulses set sticky flags in two readable registers, an event register and an interrupt register. While any interrupt bit is pending, the global pin enable is on and the line has not been silenced, the block pulls `int_n` low. Software clears flags bit by bit with read-to-clear pulses. It can also write a command register, whose two top bits are decoded here, and a configuration register, whose pin-enable and oscillator-fail-mask bits are decoded here.

A command write with bit 6 set silences the line and leaves every flag as it was. The line stays silent until the whole set of pending interrupt bits has been emptied, and only then can it re-arm. A command write with bit 7 set also silences the line, and it wipes the event register and every interrupt bit except bit 0, the power-enable event. `int_n` comes from a flop, so it is free of glitches and can drive an open-drain pad enable directly.

Top module: `irq_release_ctrl`

## Requirements
- R1: After reset `int_n` is 1, both flag registers are 0 and `ara_en_o` is 1. The pin enable and the oscillator-fail mask both reset to 1.
- R2: An `evt_set_i[i]` pulse sets bit i of both registers at the next edge. From that edge `int_n` is 0, provided the pin is enabled and not silenced.
- R3: An `rd_clr_i[i]` pulse clears bit i of both registers. A set pulse for the same bit in the same cycle wins, and the bit stays set.
- R4: A command write with bit 6 = 1 and bit 7 = 0 drives `int_n` to 1 at the next edge. Both flag registers keep their contents.
- R5: After a silencing command, `int_n` stays 1 while any interrupt bit is pending, new events included. Once the interrupt register is empty, the next event drives `int_n` to 0 again.
- R6: A command write with bit 7 = 1 clears the event register and interrupt bits 1 and up. Interrupt bit 0 is kept. The command silences the line under the same re-arm rule as R5.
- R7: An event pulse in the same cycle as a bit-7 command is kept in both registers.
- R8: Configuration bit 7 is the pin enable. While it is 0, `int_n` is 1 and `ara_en_o` is 0. Flags still collect.
- R9: Configuration bit 5 is the oscillator-fail mask. While it is 0, a set pulse on interrupt bit `OSC_IDX` (default 3) is ignored.
- R10: Configuration writes take effect at the next edge, for the gating of `int_n` and of later oscillator pulses alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_set_i | input | IRQ_W | Event set pulses, one per interrupt bit |
| rd_clr_i | input | IRQ_W | Read-to-clear pulses, one per bit |
| cmd_we_i | input | 1 | Write strobe of the command register |
| cmd_wdata_i | input | 8 | Command write data (bit 6 silence, bit 7 silence and clear) |
| cfg_we_i | input | 1 | Write strobe of the configuration register |
| cfg_wdata_i | input | 8 | Configuration data (bit 7 pin enable, bit 5 oscillator mask) |
| int_n | output | 1 | Registered active-low interrupt, 0 means pull low |
| ara_en_o | output | 1 | Alert response answering enabled |
| evt_q_o | output | IRQ_W | Event register |
| irq_q_o | output | IRQ_W | Interrupt register |

## Verification
Several relations are checked on every cycle. A low `int_n` always has a pending interrupt bit behind it and never occurs while the pin is disabled. A bit-6 command leaves the interrupt register stable and the line high. A bit-7 command leaves only bit 0 and same-cycle events. A masked oscillator pulse sets nothing. Other behaviour can only be shown by the bench's sequences. This covers re-arming only after the pending set has fully drained, set-over-clear ordering under random traffic, and the one-cycle latency of configuration writes.

// File: rtl/irq_release_pkg.sv
// Package: shared bit positions of the command and configuration registers
// decoded by the interrupt release controller.
package irq_release_pkg;
    localparam int CMD_W        = 8;
    localparam int CMD_SILENCE  = 6;  // silence line, keep flags
    localparam int CMD_WIPE     = 7;  // silence line, clear flags
    localparam int CFG_PIN_EN   = 7;  // global pin enable
    localparam int CFG_OSC_MASK = 5;  // oscillator-fail mask
    localparam int KEEP_BIT     = 0;  // interrupt bit that survives a wipe
endpackage

// File: rtl/irq_cfg_reg.sv
// Module: irq_cfg_reg
// Holds the pin-enable and oscillator-mask bits of the configuration register.
// Assumes a single-cycle write strobe. Both bits reset to 1. The next-state
// values are also exported so that registered consumers can line up with them.
module irq_cfg_reg
    import irq_release_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [CMD_W-1:0] wdata_i,
    output logic             pin_en_q,
    output logic             osc_msk_q,
    output logic             pin_en_d,
    output logic             osc_msk_d
);
    // next-state selection on a write
    always_comb begin
        pin_en_d  = we_i ? wdata_i[CFG_PIN_EN]   : pin_en_q;
        osc_msk_d = we_i ? wdata_i[CFG_OSC_MASK] : osc_msk_q;
    end

    // configuration storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_en_q  <= 1'b1;
            osc_msk_q <= 1'b1;
        end else begin
            pin_en_q  <= pin_en_d;
            osc_msk_q <= osc_msk_d;
        end
    end
endmodule

// File: rtl/irq_flag_bank.sv
// Module: irq_flag_bank
// Sticky event and interrupt registers. A set pulse wins over a read-clear
// and over a wipe. A wipe clears all event bits and all interrupt bits but
// KEEP_BIT. The oscillator bit is gated by the current mask value.
module irq_flag_bank
    import irq_release_pkg::*;
#(
    parameter int IRQ_W   = 8,
    parameter int OSC_IDX = 3
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] set_i,
    input  logic [IRQ_W-1:0] clr_i,
    input  logic             wipe_i,
    input  logic             osc_msk_i,
    output logic [IRQ_W-1:0] evt_q,
    output logic [IRQ_W-1:0] irq_q,
    output logic [IRQ_W-1:0] irq_d
);
    logic [IRQ_W-1:0] gset;
    logic [IRQ_W-1:0] evt_d;

    // per-bit set gating: only the oscillator bit depends on the mask
    for (genvar b = 0; b < IRQ_W; b++) begin : g_gate
        if (b == OSC_IDX) begin : g_osc
            assign gset[b] = set_i[b] & osc_msk_i;
        end else begin : g_plain
            assign gset[b] = set_i[b];
        end
    end

    // next state: clear first, then apply sets so that sets win
    always_comb begin
        evt_d = (wipe_i ? '0 : (evt_q & ~clr_i)) | gset;
        irq_d = (irq_q & ~clr_i) | gset;
        if (wipe_i) begin
            irq_d = ((irq_q & ~clr_i) & (IRQ_W'(1) << KEEP_BIT)) | gset;
        end
    end

    // flag storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= '0;
            irq_q <= '0;
        end else begin
            evt_q <= evt_d;
            irq_q <= irq_d;
        end
    end

    AST_WIPE_LEAVES_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wipe_i && set_i == '0) |=> (evt_q == '0 && (irq_q >> 1) == '0)); // R6
    AST_NEW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i[KEEP_BIT] && wipe_i) |=> (evt_q[KEEP_BIT] && irq_q[KEEP_BIT])); // R7
    AST_OSC_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_msk_i && !irq_q[OSC_IDX] && set_i[OSC_IDX]) |=> !irq_q[OSC_IDX]); // R9
endmodule

// File: rtl/irq_pin_drive.sv
// Module: irq_pin_drive
// Sticky silence flag and registered active-low pin. The flag is set by
// either command and kept only while interrupt bits remain pending. The pin
// is computed from next-state values, so it moves on the same edge as the flags.
module irq_pin_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic silence_i,
    input  logic pending_d,
    input  logic pin_en_d,
    output logic int_n,
    output logic silenced_q
);
    logic silenced_d;

    // silence persists until the pending set is empty
    always_comb silenced_d = (silenced_q | silence_i) & pending_d;

    // silence flag and glitch-free pin register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            silenced_q <= 1'b0;
            int_n      <= 1'b1;
        end else begin
            silenced_q <= silenced_d;
            int_n      <= ~(pin_en_d & pending_d & ~silenced_d);
        end
    end

    AST_SILENT_MEANS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        silenced_q |-> int_n); // R5
endmodule

// File: rtl/irq_release_ctrl.sv
// Module: irq_release_ctrl (top)
// Interrupt pin release controller. Decodes bits 6 and 7 of the command
// write and instantiates the configuration register, the flag bank and the
// pin driver. Assumes write strobes and event pulses last one cycle.
module irq_release_ctrl
    import irq_release_pkg::*;
#(
    parameter int IRQ_W   = 8,
    parameter int OSC_IDX = 3
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] evt_set_i,
    input  logic [IRQ_W-1:0] rd_clr_i,
    input  logic             cmd_we_i,
    input  logic [CMD_W-1:0] cmd_wdata_i,
    input  logic             cfg_we_i,
    input  logic [CMD_W-1:0] cfg_wdata_i,
    output logic             int_n,
    output logic             ara_en_o,
    output logic [IRQ_W-1:0] evt_q_o,
    output logic [IRQ_W-1:0] irq_q_o
);
    logic             pin_en_q, osc_msk_q, pin_en_d, osc_msk_d;
    logic             wipe, silence;
    logic [IRQ_W-1:0] irq_d;
    logic             silenced_q;

    // command decode
    always_comb begin
        wipe    = cmd_we_i & cmd_wdata_i[CMD_WIPE];
        silence = cmd_we_i & (cmd_wdata_i[CMD_WIPE] | cmd_wdata_i[CMD_SILENCE]);
    end

    irq_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (cfg_we_i),
        .wdata_i   (cfg_wdata_i),
        .pin_en_q  (pin_en_q),
        .osc_msk_q (osc_msk_q),
        .pin_en_d  (pin_en_d),
        .osc_msk_d (osc_msk_d)
    );

    irq_flag_bank #(.IRQ_W(IRQ_W), .OSC_IDX(OSC_IDX)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (evt_set_i),
        .clr_i     (rd_clr_i),
        .wipe_i    (wipe),
        .osc_msk_i (osc_msk_q),
        .evt_q     (evt_q_o),
        .irq_q     (irq_q_o),
        .irq_d     (irq_d)
    );

    irq_pin_drive u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .silence_i  (silence),
        .pending_d  (|irq_d),
        .pin_en_d   (pin_en_d),
        .int_n      (int_n),
        .silenced_q (silenced_q)
    );

    assign ara_en_o = pin_en_q;

    AST_LOW_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        !int_n |-> (irq_q_o != '0)); // R2
    AST_DISABLED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_en_q |-> int_n); // R8
    AST_SILENCE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we_i && cmd_wdata_i[CMD_SILENCE] && !cmd_wdata_i[CMD_WIPE]
         && evt_set_i == '0 && rd_clr_i == '0)
        |=> ($stable(irq_q_o) && $stable(evt_q_o) && int_n)); // R4
    AST_REARM_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (silenced_q && irq_d != '0 && !(pin_en_d == 1'b0)) |=> int_n); // R5
endmodule

// File: tb/irq_release_ctrl_bench.sv
module irq_release_ctrl_bench;
    localparam int W   = 8;
    localparam int OSC = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] evt_set = '0, rd_clr = '0;
    logic         cmd_we = 1'b0, cfg_we = 1'b0;
    logic [7:0]   cmd_wd = '0, cfg_wd = '0;
    logic         int_n, ara_en;
    logic [W-1:0] evt_q, irq_q;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    // expected state held by the bench
    logic [W-1:0] m_evt = '0, m_irq = '0;
    logic         m_sil = 1'b0, m_en = 1'b1, m_msk = 1'b1, m_int = 1'b1;

    always #2.5 clk = ~clk;

    irq_release_ctrl #(.IRQ_W(W), .OSC_IDX(OSC)) u_irq_release_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_set_i(evt_set), .rd_clr_i(rd_clr),
        .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wd), .cfg_we_i(cfg_we),
        .cfg_wdata_i(cfg_wd), .int_n(int_n), .ara_en_o(ara_en),
        .evt_q_o(evt_q), .irq_q_o(irq_q)
    );

    // watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // expected event register after one edge
    function automatic logic [W-1:0] f_evt(logic [W-1:0] e, logic [W-1:0] s,
                                           logic [W-1:0] c, logic wipe);
        return (wipe ? '0 : (e & ~c)) | s;
    endfunction

    // expected interrupt register after one edge
    function automatic logic [W-1:0] f_irq(logic [W-1:0] q, logic [W-1:0] s,
                                           logic [W-1:0] c, logic wipe);
        return ((q & ~c) & (wipe ? W'(1) : {W{1'b1}})) | s;
    endfunction

    task automatic check(string tag);
        total++;
        if (int_n !== m_int || evt_q !== m_evt || irq_q !== m_irq || ara_en !== m_en) begin
            bad++;
            $display("FAIL %s: actual int_n=%b evt=%h irq=%h ara=%b expected int_n=%b evt=%h irq=%h ara=%b",
                     tag, int_n, evt_q, irq_q, ara_en, m_int, m_evt, m_irq, m_en);
        end
    endtask

    // drive one cycle, advance the expected state, check after the edge
    task automatic step(logic [W-1:0] s, logic [W-1:0] c, logic cw, logic [7:0] cd,
                        logic fw, logic [7:0] fd, string tag);
        logic [W-1:0] gs;
        logic wipe, sil;
        evt_set = s; rd_clr = c; cmd_we = cw; cmd_wd = cd; cfg_we = fw; cfg_wd = fd;
        gs = s;
        if (!m_msk) gs[OSC] = 1'b0;
        wipe = cw & cd[7];
        sil  = cw & (cd[7] | cd[6]);
        @(posedge clk);
        m_evt = f_evt(m_evt, gs, c, wipe);
        m_irq = f_irq(m_irq, gs, c, wipe);
        m_sil = (m_sil | sil) & (m_irq != '0);
        if (fw) begin m_en = fd[7]; m_msk = fd[5]; end
        m_int = ~(m_en & (m_irq != '0) & ~m_sil);
        @(negedge clk);
        evt_set = '0; rd_clr = '0; cmd_we = 1'b0; cfg_we = 1'b0;
        check(tag);
    endtask

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        check("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release");

        step(8'h04, 8'h00, 0, 8'h00, 0, 8'h00, "R2 set bit2");
        step(8'h00, 8'h04, 0, 8'h00, 0, 8'h00, "R3 clear bit2");
        step(8'h02, 8'h02, 0, 8'h00, 0, 8'h00, "R3 set beats clear");
        step(8'h10, 8'h02, 0, 8'h00, 0, 8'h00, "R2 set bit4");
        step(8'h00, 8'h00, 1, 8'h40, 0, 8'h00, "R4 silence keeps flags");
        step(8'h20, 8'h00, 0, 8'h00, 0, 8'h00, "R5 new event while silent");
        step(8'h00, 8'h10, 0, 8'h00, 0, 8'h00, "R5 partly drained");
        step(8'h00, 8'h20, 0, 8'h00, 0, 8'h00, "R5 drained");
        step(8'h02, 8'h00, 0, 8'h00, 0, 8'h00, "R5 rearmed");
        step(8'h05, 8'h00, 0, 8'h00, 0, 8'h00, "R2 bits 0 and 2");
        step(8'h00, 8'h00, 1, 8'h80, 0, 8'h00, "R6 wipe keeps bit0");
        step(8'h08, 8'h00, 0, 8'h00, 0, 8'h00, "R6 still silent");
        step(8'h00, 8'h09, 0, 8'h00, 0, 8'h00, "R6 drained");
        step(8'h40, 8'h00, 0, 8'h00, 0, 8'h00, "R6 rearmed");
        step(8'h01, 8'h00, 1, 8'hC0, 0, 8'h00, "R7 event beats wipe");
        step(8'h00, 8'hFF, 0, 8'h00, 0, 8'h00, "R3 clear all");
        step(8'h02, 8'h00, 0, 8'h00, 1, 8'h20, "R8 disabled pin");
        step(8'h00, 8'h00, 0, 8'h00, 1, 8'hA0, "R10 enable next edge");
        step(8'h00, 8'h02, 0, 8'h00, 1, 8'h80, "R9 mask off");
        step(8'h08, 8'h00, 0, 8'h00, 0, 8'h00, "R9 osc ignored");
        step(8'h08, 8'h00, 0, 8'h00, 1, 8'hA0, "R10 mask uses old value");
        step(8'h08, 8'h00, 0, 8'h00, 0, 8'h00, "R9 osc accepted");
        step(8'h00, 8'hFF, 0, 8'h00, 0, 8'h00, "R3 clear all");

        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] s, c;
            logic cw, fw;
            logic [7:0] cd, fd;
            s  = ($urandom % 4 == 0) ? W'($urandom) & W'($urandom) : '0;
            c  = ($urandom % 3 == 0) ? W'($urandom) : '0;
            cw = ($urandom % 12 == 0);
            cd = 8'($urandom);
            fw = ($urandom % 25 == 0);
            fd = {($urandom % 4 != 0), 1'b0, 1'($urandom), 5'b0};
            step(s, c, cw, cd, fw, fd, "R2 R3 R5 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule